// File: doc/BRIEF.md
# Cross-Clock Event Bridge with Busy Flag

This block carries a single-cycle event from one clock domain into a second, unrelated clock domain. The two clocks may run at any frequency ratio and any phase offset. On the source side the block watches an event input for a rising edge. A detected edge is accepted only while the block is idle, and it flips a request toggle. The destination side synchronizes that toggle. When it sees the toggle change, it emits a pulse exactly one destination cycle wide and flips its own toggle. That toggle travels back to the source as an acknowledge.

The source-side busy flag is high for the whole round trip. It lets the sender know when the next event can be offered. Edges offered while busy is high are dropped.

A source reset never cancels a transfer that is already under way: the request toggle sits outside the reset. The destination domain has no reset. Each synchronizer chain has a parameterized depth, four flops by default.

Top module: `xclk_event_bridge`

## Requirements
- R1: A rising edge on `evt_i` is accepted when it is sampled in the source clock while `busy_o` is low. A rising edge means high in this cycle and low in the previous cycle. `busy_o` is high from the cycle after acceptance.
- R2: Each accepted edge produces exactly one pulse on `evt_o`, and that pulse is exactly one destination cycle wide.
- R3: A rising edge on `evt_i` that arrives while `busy_o` is high is dropped. It produces no pulse on `evt_o`.
- R4: `busy_o` stays high until the acknowledge returns from the destination and then falls. A new edge offered after it falls is accepted.
- R5: Holding `evt_i` high for many cycles counts as one event only. It produces one pulse, and `busy_o` still clears while the input stays high.
- R6: Asserting `rst_src_n` low during a transfer does not cancel that transfer. `busy_o` stays high and the destination pulse still arrives.
- R7: If `evt_i` is held high across the release of `rst_src_n`, no transfer starts.
- R8: After reset with no transfer in flight, `busy_o` is low and `evt_o` stays low.
- R9: R1 to R5 hold when the destination clock is slower than the source clock, faster than it, and of a similar but unrelated period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source-domain clock |
| rst_src_n | input | 1 | Source-domain reset, asynchronous, active low, released synchronously |
| evt_i | input | 1 | Event input; a rising edge requests a transfer |
| busy_o | output | 1 | High while a transfer round trip is outstanding |
| clk_dst | input | 1 | Destination-domain clock |
| evt_o | output | 1 | One-cycle destination event pulse |

## Verification
The bench builds the bridge with the default four-stage chains. This gives a round trip of roughly eight to ten clock cycles across both domains. That window is long enough for the bench to offer several extra edges while busy is high and to apply a reset in the middle of a transfer. The bench swaps the destination clock period between runs while keeping a 10 ns source clock. The three periods used are 34 ns, 4 ns and 18 ns, which give slow, fast and near-equal destination timing with drifting phase.

// File: rtl/xeb_pkg.sv
package xeb_pkg;
  // Default depth of every synchronizer chain in the bridge.
  localparam int unsigned XEB_DEF_STAGES = 4;
  // Smallest depth that still resolves metastability.
  localparam int unsigned XEB_MIN_STAGES = 2;
endpackage

// File: rtl/xeb_sync_chain.sv
module xeb_sync_chain #(
  parameter int unsigned STAGES = xeb_pkg::XEB_DEF_STAGES
) (
  input  logic clk,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [LAST:0] ff_q;
  logic [LAST:0] ff_nxt;

  always_comb begin
    ff_nxt = {ff_q[LAST-1:0], d_i};
  end

  // No reset: the chain only ever mirrors a toggle that is itself never reset.
  genvar gi;
  generate
    for (gi = 0; gi <= LAST; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        ff_q[gi] <= ff_nxt[gi];
      end
    end
  endgenerate

  assign q_o = ff_q[LAST];

  initial begin
    assert (STAGES >= xeb_pkg::XEB_MIN_STAGES)
      else $error("xeb_sync_chain: STAGES below minimum");
  end
endmodule

// File: rtl/xeb_src_ctrl.sv
module xeb_src_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_i,
  input  logic ack_s_i,
  output logic req_tgl_o,
  output logic busy_o
);
  logic evt_q, evt_q_nxt;
  logic req_q, req_nxt;
  logic accept;

  always_comb begin
    busy_o    = req_q ^ ack_s_i;
    accept    = evt_i & ~evt_q & ~busy_o;
    req_nxt   = ~req_q;
    evt_q_nxt = evt_i;
  end

  // Edge-detect history resets high so a level held through reset is no edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b1;
    else        evt_q <= evt_q_nxt;
  end

  // Request toggle outside reset: a launched transfer must run to completion.
  always_ff @(posedge clk) begin
    if (accept) req_q <= req_nxt;
  end

  assign req_tgl_o = req_q;

  a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && !evt_q && !busy_o) |=> busy_o);

  a_r3_no_launch_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(req_q));

  a_r4_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> !$stable(ack_s_i));

  a_r5_level_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && evt_q) |=> $stable(req_q));
endmodule

// File: rtl/xeb_dst_gen.sv
module xeb_dst_gen (
  input  logic clk,
  input  logic req_s_i,
  output logic pulse_o,
  output logic ack_tgl_o
);
  logic tgl_q, tgl_nxt;
  logic pls_q, pls_nxt;

  always_comb begin
    tgl_nxt = req_s_i;
    pls_nxt = req_s_i ^ tgl_q;
  end

  always_ff @(posedge clk) begin
    tgl_q <= tgl_nxt;
    pls_q <= pls_nxt;
  end

  assign pulse_o   = pls_q;
  assign ack_tgl_o = tgl_q;
endmodule

// File: rtl/xclk_event_bridge.sv
module xclk_event_bridge #(
  parameter int unsigned SYNC_STAGES = xeb_pkg::XEB_DEF_STAGES
) (
  input  logic clk_src,
  input  logic rst_src_n,
  input  logic evt_i,
  output logic busy_o,
  input  logic clk_dst,
  output logic evt_o
);
  logic req_tgl, req_s, ack_tgl, ack_s;

  xeb_src_ctrl u_src (
    .clk       (clk_src),
    .rst_n     (rst_src_n),
    .evt_i     (evt_i),
    .ack_s_i   (ack_s),
    .req_tgl_o (req_tgl),
    .busy_o    (busy_o)
  );

  xeb_sync_chain #(.STAGES(SYNC_STAGES)) u_fwd_sync (
    .clk (clk_dst),
    .d_i (req_tgl),
    .q_o (req_s)
  );

  xeb_dst_gen u_dst (
    .clk       (clk_dst),
    .req_s_i   (req_s),
    .pulse_o   (evt_o),
    .ack_tgl_o (ack_tgl)
  );

  xeb_sync_chain #(.STAGES(SYNC_STAGES)) u_ack_sync (
    .clk (clk_src),
    .d_i (ack_tgl),
    .q_o (ack_s)
  );

  a_r2_one_cycle_pulse: assert property (@(posedge clk_dst) disable iff (!rst_src_n)
    evt_o |=> !evt_o);
endmodule

// File: tb/tb_xclk_event_bridge.sv
`timescale 1ns/1ps
module tb_xclk_event_bridge;
  localparam int unsigned STG = 4;

  logic clk_src = 1'b0;
  logic clk_dst = 1'b0;
  logic rst_src_n = 1'b0;
  logic evt_i = 1'b0;
  logic busy_o, evt_o;
  realtime dst_half = 17.0;

  int n_chk = 0, n_fail = 0;
  int pulses = 0, wide_err = 0;
  bit prev_hi = 1'b0;
  bit done = 1'b0;

  xclk_event_bridge #(.SYNC_STAGES(STG)) dut (
    .clk_src(clk_src), .rst_src_n(rst_src_n), .evt_i(evt_i), .busy_o(busy_o),
    .clk_dst(clk_dst), .evt_o(evt_o)
  );

  always #5 clk_src = ~clk_src;
  always #(dst_half) clk_dst = ~clk_dst;

  always @(negedge clk_dst) begin
    if (evt_o) begin
      pulses++;
      if (prev_hi) wide_err++;
    end
    prev_hi = evt_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_dst);
    @(negedge clk_src);
  endtask

  task automatic wait_idle(input string req);
    int n = 0;
    while (busy_o && n < 400) begin
      @(negedge clk_src);
      n++;
    end
    chk(!busy_o, req, int'(busy_o), 0);
  endtask

  task automatic fire();
    @(negedge clk_src);
    evt_i = 1'b1;
    @(negedge clk_src);
    evt_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_src_n = 1'b0;
    repeat (3) @(negedge clk_src);
    rst_src_n = 1'b1;
    settle();
    chk(busy_o == 1'b0, "R8 busy after reset", int'(busy_o), 0);
    chk(pulses == 0, "R8 no pulse after reset", pulses, 0);
  endtask

  task automatic t_single();
    int p0 = pulses;
    @(negedge clk_src);
    evt_i = 1'b1;
    @(negedge clk_src);
    evt_i = 1'b0;
    chk(busy_o == 1'b1, "R1 busy after accept", int'(busy_o), 1);
    wait_idle("R4 busy clears");
    settle();
    chk(pulses == p0 + 1, "R2 single pulse", pulses - p0, 1);
  endtask

  task automatic t_busy_drop();
    int p0 = pulses;
    fire();
    for (int k = 0; k < 3; k++) begin
      chk(busy_o == 1'b1, "R3 busy during drop", int'(busy_o), 1);
      fire();
    end
    wait_idle("R3 idle after drop");
    settle();
    chk(pulses == p0 + 1, "R3 busy edges dropped", pulses - p0, 1);
  endtask

  task automatic t_held();
    int p0 = pulses;
    @(negedge clk_src);
    evt_i = 1'b1;
    repeat (60) @(negedge clk_src);
    chk(busy_o == 1'b0, "R5 busy clears while held", int'(busy_o), 0);
    evt_i = 1'b0;
    settle();
    chk(pulses == p0 + 1, "R5 held level one pulse", pulses - p0, 1);
  endtask

  task automatic t_back_to_back();
    int p0 = pulses;
    for (int k = 0; k < 3; k++) begin
      fire();
      wait_idle("R4 back to back idle");
    end
    settle();
    chk(pulses == p0 + 3, "R4 back to back count", pulses - p0, 3);
  endtask

  task automatic t_reset_inflight();
    int p0 = pulses;
    fire();
    #1 rst_src_n = 1'b0;
    repeat (2) @(negedge clk_src);
    chk(busy_o == 1'b1, "R6 busy held in reset", int'(busy_o), 1);
    rst_src_n = 1'b1;
    wait_idle("R6 idle after reset");
    settle();
    chk(pulses == p0 + 1, "R6 pulse survives reset", pulses - p0, 1);
  endtask

  task automatic t_held_reset();
    int p0 = pulses;
    @(negedge clk_src);
    rst_src_n = 1'b0;
    evt_i = 1'b1;
    repeat (3) @(negedge clk_src);
    rst_src_n = 1'b1;
    repeat (30) @(negedge clk_src);
    chk(busy_o == 1'b0, "R7 no busy after held release", int'(busy_o), 0);
    evt_i = 1'b0;
    settle();
    chk(pulses == p0, "R7 no pulse after held release", pulses - p0, 0);
  endtask

  task automatic run_ratio(input realtime half, input string tag);
    dst_half = half;
    repeat (10) @(negedge clk_src);
    t_single();
    t_busy_drop();
    t_held();
    t_back_to_back();
    t_reset_inflight();
    t_held_reset();
    chk(wide_err == 0, {"R2 pulse width ", tag}, wide_err, 0);
    chk(!busy_o, {"R9 idle at end ", tag}, int'(busy_o), 0);
  endtask

  initial begin
    t_reset();
    run_ratio(17.0, "slow dst");
    run_ratio(2.0, "fast dst");
    run_ratio(9.0, "near dst");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_src);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule